// File: doc/BRIEF.md
# Video Fetch Address Snooper

This block sits beside a cartridge mapper's register file and watches the video address bus. It picks out the video chip's name-table tile fetches and one narrow slice of pattern-table reads. Depending on a 2-bit auto-update mode, it copies chosen address bits into specific bits of three host registers: a control register, a low character-bank register and a high character-bank register. Bank and mirroring selections can therefore follow the picture as it is drawn, with no CPU involvement.

The block also keeps address bits [11:4] of the most recent tile fetch, so the CPU can read them back as one byte. The register file stays with the host. For each register the block gives a per-bit write-enable mask and the matching data byte, and the host merges them into its flops. The host has a per-register write flag that holds back the block's update in any cycle where the CPU writes that register.

Top module: `vfs_snoop`

## Requirements
- R1: After reset, all three write-enable masks and the readback byte are zero.
- R2: A fetch is acted on once for each rising edge of the read strobe. The resulting masks appear in the clock cycle after the cycle in which the strobe is first seen high, and they last one cycle. Data bits outside a mask are zero, and a strobe held high gives no further update.
- R3: A tile fetch is a read in 0x2000-0x2FFF whose address bits [9:6] are not all ones. Attribute bytes (bits [9:6] = 4'hF) and addresses at 0x3000 and above are not tile fetches.
- R4: On every tile fetch, in any mode, the readback byte takes address bits [11:4]. It keeps its value at all other times.
- R5: In mode 2'b00, no mask bit is ever set.
- R6: In mode 2'b01, a tile fetch writes high bank bit 0 with address bit 0, and high bank bit 1 with address bit 5. It writes control bit 6 with address bit 5, and low bank bit 0 with address bit 10 XOR bit 11.
- R7: In mode 2'b10, a read in 0x1FD0-0x1FEF writes control bit 4 and low bank bit 0, both with address bit 4. Reads outside that window, including tile fetches, write nothing.
- R8: In mode 2'b11, a tile fetch writes low bank bit 0 with address bit 0, low bank bit 1 with address bit 5, and control bit 1 with address bit 10 XOR bit 11.
- R9: host_wr_i bit 0 (control), bit 1 (low bank) and bit 2 (high bank) force that register's mask to zero in the same cycle. The other registers are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vaddr_i | input | 14 | Video address bus |
| vrd_i | input | 1 | Video read strobe, active high |
| vmode_i | input | 2 | Auto-update mode |
| host_wr_i | input | 3 | CPU write to control / low bank / high bank this cycle |
| ctl_we_o | output | 8 | Control register bit write mask |
| ctl_d_o | output | 8 | Control register override data |
| chrl_we_o | output | 8 | Low bank register bit write mask |
| chrl_d_o | output | 8 | Low bank register override data |
| chrh_we_o | output | 8 | High bank register bit write mask |
| chrh_d_o | output | 8 | High bank register override data |
| nt_addr_o | output | 8 | Bits [11:4] of the latest tile fetch |

## Verification
A fault in the edge tracker shows up on the masks exactly one cycle after the strobe. Either a held strobe produces a second update, or an update is missing altogether. A fault in address classification shows as the wrong register bits being set, or the readback byte moving on an attribute fetch. Both are visible on the first fetch of the kind concerned. The readback latch is the only long-lived state, so a bad value there stays until the next tile fetch and is checked after every fetch.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NREG = 3;
  localparam int unsigned REG_CTL = 0;
  localparam int unsigned REG_CHRL = 1;
  localparam int unsigned REG_CHRH = 2;

  typedef enum logic [1:0] {
    VM_OFF  = 2'b00,
    VM_NT_A = 2'b01,
    VM_PAT  = 2'b10,
    VM_NT_B = 2'b11
  } vmode_e;

  typedef struct packed {
    logic [DW-1:0] we;
    logic [DW-1:0] d;
  } ovr_t;

  typedef struct packed {
    logic b0;
    logic b4;
    logic b5;
    logic bx;  // bit10 ^ bit11
  } abits_t;
endpackage

// File: rtl/vfs_decode.sv
module vfs_decode #(
  parameter int unsigned AW = 14,
  parameter logic [13:0] PAT_LO = 14'h1FD0,
  parameter logic [13:0] PAT_HI = 14'h1FEF
) (
  input  logic [AW-1:0] addr_i,
  output logic          is_nt_o,
  output logic          is_pat_o,
  output vfs_pkg::abits_t ab_o
);
  logic in_nt_space;
  logic attr;

  assign in_nt_space = (addr_i[13:12] == 2'b10);
  assign attr        = &addr_i[9:6];
  assign is_nt_o     = in_nt_space & ~attr;
  assign is_pat_o    = (addr_i >= PAT_LO) && (addr_i <= PAT_HI);

  assign ab_o.b0 = addr_i[0];
  assign ab_o.b4 = addr_i[4];
  assign ab_o.b5 = addr_i[5];
  assign ab_o.bx = addr_i[10] ^ addr_i[11];
endmodule

// File: rtl/vfs_edge.sv
module vfs_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/vfs_route.sv
module vfs_route
  import vfs_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       is_nt_i,
  input  logic       is_pat_i,
  input  abits_t     ab_i,
  output ovr_t [NREG-1:0] ovr_o
);
  vmode_e mode;
  assign mode = vmode_e'(mode_i);

  always_comb begin
    ovr_o = '0;
    unique case (mode)
      VM_NT_A: if (is_nt_i) begin
        ovr_o[REG_CHRH].we[0] = 1'b1;  ovr_o[REG_CHRH].d[0] = ab_i.b0;
        ovr_o[REG_CHRH].we[1] = 1'b1;  ovr_o[REG_CHRH].d[1] = ab_i.b5;
        ovr_o[REG_CTL].we[6]  = 1'b1;  ovr_o[REG_CTL].d[6]  = ab_i.b5;
        ovr_o[REG_CHRL].we[0] = 1'b1;  ovr_o[REG_CHRL].d[0] = ab_i.bx;
      end
      VM_PAT: if (is_pat_i) begin
        ovr_o[REG_CTL].we[4]  = 1'b1;  ovr_o[REG_CTL].d[4]  = ab_i.b4;
        ovr_o[REG_CHRL].we[0] = 1'b1;  ovr_o[REG_CHRL].d[0] = ab_i.b4;
      end
      VM_NT_B: if (is_nt_i) begin
        ovr_o[REG_CHRL].we[0] = 1'b1;  ovr_o[REG_CHRL].d[0] = ab_i.b0;
        ovr_o[REG_CHRL].we[1] = 1'b1;  ovr_o[REG_CHRL].d[1] = ab_i.b5;
        ovr_o[REG_CTL].we[1]  = 1'b1;  ovr_o[REG_CTL].d[1]  = ab_i.bx;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vfs_snoop.sv
module vfs_snoop
  import vfs_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] vaddr_i,
  input  logic          vrd_i,
  input  logic [1:0]    vmode_i,
  input  logic [NREG-1:0] host_wr_i,
  output logic [DW-1:0] ctl_we_o,
  output logic [DW-1:0] ctl_d_o,
  output logic [DW-1:0] chrl_we_o,
  output logic [DW-1:0] chrl_d_o,
  output logic [DW-1:0] chrh_we_o,
  output logic [DW-1:0] chrh_d_o,
  output logic [DW-1:0] nt_addr_o
);
  localparam int unsigned RB_LSB = 4;

  logic   is_nt, is_pat, ev;
  abits_t ab;
  ovr_t [NREG-1:0] ovr_c, ovr_q, ovr_g;
  logic [DW-1:0] nt_q;

  vfs_decode #(.AW(AW)) u_dec (
    .addr_i  (vaddr_i),
    .is_nt_o (is_nt),
    .is_pat_o(is_pat),
    .ab_o    (ab)
  );

  vfs_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (vrd_i),
    .rise_o(ev)
  );

  vfs_route u_route (
    .mode_i  (vmode_i),
    .is_nt_i (is_nt),
    .is_pat_i(is_pat),
    .ab_i    (ab),
    .ovr_o   (ovr_c)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ovr_q[r] <= '0;
      else if (ev)  ovr_q[r] <= ovr_c[r];
      else          ovr_q[r] <= '0;
    end
    // CPU write to the same register wins
    assign ovr_g[r].we = host_wr_i[r] ? '0 : ovr_q[r].we;
    assign ovr_g[r].d  = host_wr_i[r] ? '0 : ovr_q[r].d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         nt_q <= '0;
    else if (ev && is_nt) nt_q <= vaddr_i[RB_LSB +: DW];
  end

  assign ctl_we_o  = ovr_g[REG_CTL].we;
  assign ctl_d_o   = ovr_g[REG_CTL].d;
  assign chrl_we_o = ovr_g[REG_CHRL].we;
  assign chrl_d_o  = ovr_g[REG_CHRL].d;
  assign chrh_we_o = ovr_g[REG_CHRH].we;
  assign chrh_d_o  = ovr_g[REG_CHRH].d;
  assign nt_addr_o = nt_q;
endmodule

// File: rtl/vfs_snoop_chk.sv
module vfs_snoop_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [13:0] vaddr_i,
  input logic        vrd_i,
  input logic [1:0]  vmode_i,
  input logic [2:0]  host_wr_i,
  input logic [7:0]  ctl_we_o,
  input logic [7:0]  chrl_we_o,
  input logic [7:0]  chrh_we_o,
  input logic [7:0]  nt_addr_o
);
  logic any_we;
  assign any_we = |{ctl_we_o, chrl_we_o, chrh_we_o};

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_we |=> !any_we);

  p_attr_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vaddr_i[13:12] == 2'b10 && vaddr_i[9:6] == 4'hF) |=> (chrh_we_o == 8'h00));

  p_rb_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(vrd_i) |-> $stable(nt_addr_o));

  p_off_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vmode_i == 2'b00) |=> !any_we);

  p_pat_no_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vmode_i == 2'b10) |=> (chrh_we_o == 8'h00));
endmodule

bind vfs_snoop vfs_snoop_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .vaddr_i  (vaddr_i),
  .vrd_i    (vrd_i),
  .vmode_i  (vmode_i),
  .host_wr_i(host_wr_i),
  .ctl_we_o (ctl_we_o),
  .chrl_we_o(chrl_we_o),
  .chrh_we_o(chrh_we_o),
  .nt_addr_o(nt_addr_o)
);

// File: tb/sim_vfs_snoop.sv
`timescale 1ns/1ps
module sim_vfs_snoop;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] vaddr_i = '0;
  logic        vrd_i = 1'b0;
  logic [1:0]  vmode_i = 2'b00;
  logic [2:0]  host_wr_i = '0;
  logic [7:0]  ctl_we_o, ctl_d_o, chrl_we_o, chrl_d_o, chrh_we_o, chrh_d_o, nt_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  vfs_snoop u0 (.*);

  task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] outs();
    return {ctl_we_o, ctl_d_o, chrl_we_o, chrl_d_o, chrh_we_o, chrh_d_o, nt_addr_o};
  endfunction

  // one fetch; checks outputs in the cycle after the strobe and that they clear
  task automatic fetch(input string req, input logic [1:0] m, input logic [13:0] a,
                       input logic [2:0] hw, input logic [55:0] exp);
    @(negedge clk_i);
    vmode_i = m; vaddr_i = a; vrd_i = 1'b1; host_wr_i = hw;
    @(negedge clk_i);
    chk(req, outs(), exp);
    vrd_i = 1'b0; host_wr_i = '0;
    @(negedge clk_i);
    chk({req, " clear"}, outs(), {48'h0, exp[7:0]});
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1", outs(), 56'h0);
  endtask

  task automatic t_mode01();
    // 0x2C21: a0=1 a5=1 a10^a11=0
    fetch("R6", 2'b01, 14'h2C21, 3'b000, {8'h40,8'h40, 8'h01,8'h00, 8'h03,8'h03, 8'hC2});
    // 0x2400: a0=0 a5=0 xor=1
    fetch("R6", 2'b01, 14'h2400, 3'b000, {8'h40,8'h00, 8'h01,8'h01, 8'h03,8'h00, 8'h40});
    // last tile byte before attributes
    fetch("R3", 2'b01, 14'h23BF, 3'b000, {8'h40,8'h40, 8'h01,8'h00, 8'h03,8'h03, 8'h3B});
  endtask

  task automatic t_exclude();
    fetch("R3", 2'b01, 14'h23C0, 3'b000, {48'h0, 8'h3B});
    fetch("R3", 2'b01, 14'h27FF, 3'b000, {48'h0, 8'h3B});
    fetch("R3", 2'b01, 14'h3000, 3'b000, {48'h0, 8'h3B});
  endtask

  task automatic t_mode00();
    fetch("R5", 2'b00, 14'h2123, 3'b000, {48'h0, 8'h12});
    fetch("R5", 2'b00, 14'h1FD0, 3'b000, {48'h0, 8'h12});
  endtask

  task automatic t_mode10();
    fetch("R7", 2'b10, 14'h1FD5, 3'b000, {8'h10,8'h10, 8'h01,8'h01, 16'h0, 8'h12});
    fetch("R7", 2'b10, 14'h1FE3, 3'b000, {8'h10,8'h00, 8'h01,8'h00, 16'h0, 8'h12});
    fetch("R7", 2'b10, 14'h1FCF, 3'b000, {48'h0, 8'h12});
    fetch("R7", 2'b10, 14'h1FF0, 3'b000, {48'h0, 8'h12});
    fetch("R4", 2'b10, 14'h2AB1, 3'b000, {48'h0, 8'hAB});
  endtask

  task automatic t_mode11();
    // 0x2821: a0=1 a5=1 xor=1
    fetch("R8", 2'b11, 14'h2821, 3'b000, {8'h02,8'h02, 8'h03,8'h03, 16'h0, 8'h82});
    fetch("R8", 2'b11, 14'h2C00, 3'b000, {8'h02,8'h00, 8'h03,8'h00, 16'h0, 8'hC0});
  endtask

  task automatic t_prio();
    fetch("R9", 2'b01, 14'h2C21, 3'b010, {8'h40,8'h40, 16'h0, 8'h03,8'h03, 8'hC2});
    fetch("R9", 2'b01, 14'h2C21, 3'b101, {16'h0, 8'h01,8'h00, 16'h0, 8'hC2});
  endtask

  task automatic t_held();
    @(negedge clk_i);
    vmode_i = 2'b11; vaddr_i = 14'h2821; vrd_i = 1'b1;
    @(negedge clk_i);
    chk("R2 first", outs(), {8'h02,8'h02, 8'h03,8'h03, 16'h0, 8'h82});
    vaddr_i = 14'h2400;
    @(negedge clk_i);
    chk("R2 held", outs(), {48'h0, 8'h82});
    vrd_i = 1'b0;
    @(negedge clk_i);
    chk("R2 idle", outs(), {48'h0, 8'h82});
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        t_reset();
        t_mode01();
        t_exclude();
        t_mode00();
        t_mode10();
        t_mode11();
        t_prio();
        t_held();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule